// File: doc/BRIEF.md
# Compare-Match Timer Counter

This block is a 16-bit up-counter steered by one 8-bit control register. The register picks which pulse advances the counter. The choices are every system clock, the system clock divided by 2, 4 or 8, a subclock tick, that tick divided by 4 or 16, or rising edges on an external event pin. The register also chooses between free-running counting and clearing on compare match A. Finally, it sets the starting levels of two compare outputs, C and D.

Every rate is made with one-cycle enable pulses inside the single system-clock domain. No clock is derived. The subclock arrives as a one-cycle tick, already in the system clock domain. The external pin passes through a two-flop synchronizer and then an edge detector.

The three compare values are plain input vectors. A match on A, C or D raises a one-cycle flag. Each of outputs C and D holds its software-set level until its first match. After that, the output toggles on every match, and further writes of its level bit do nothing.

Top module: `cmp_timer`

## Requirements
- R1: While reset is asserted, regRdata is 0x00, count is 0, outC and outD are 0, and matchA is 0 when cmpA is not 0.
- R2: regRdata bits 7..2 return the last written bits 7..2, and bits 1..0 always read 0 regardless of the written value.
- R3: Clock-select field bits 6..4 equal to 000, 001, 010 or 011 advance count once every 1, 2, 4 or 8 system clocks.
- R4: Clock-select codes 100, 101 and 110 advance count once every 1, 4 or 16 subTick pulses.
- R5: Code 111 advances count once per 0-to-1 change of extEvent. A level held high counts once, and no edge means no count. The increment shows after the third rising clock edge that follows the input's rise.
- R6: With bit 7 at 0, count steps by one on each count enable and wraps from 0xFFFF to 0x0000.
- R7: With bit 7 at 1, the count enable that finds count equal to cmpA loads 0 instead of count+1.
- R8: matchA, matchC and matchD are high exactly in a count-enable cycle where count equals cmpA, cmpC or cmpD respectively.
- R9: Before its first match, outD follows written bit 3 and outC follows written bit 2 from the cycle after the write, where 1 drives high.
- R10: Each match on C or D inverts the corresponding output at the clock edge that ends the match cycle.
- R11: After its first match, writes of bit 2 or bit 3 leave outC or outD unchanged.
- R12: When a register write and a first match on the same output share a cycle, the output inverts its previous level and the written level bit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| subTick | input | 1 | One-cycle subclock tick enable |
| extEvent | input | 1 | Asynchronous external event pin |
| regWe | input | 1 | Control register write strobe |
| regWdata | input | 8 | Control register write data |
| regRdata | output | 8 | Control register read data |
| cmpA | input | 16 | Compare value A (clear source) |
| cmpC | input | 16 | Compare value C |
| cmpD | input | 16 | Compare value D |
| count | output | 16 | Counter value |
| matchA | output | 1 | Compare match A flag |
| matchC | output | 1 | Compare match C flag |
| matchD | output | 1 | Compare match D flag |
| outC | output | 1 | Compare output C |
| outD | output | 1 | Compare output D |

## Verification
Two functions can land on the same clock edge: a software write of the preset level bits, and the first compare match of an output. The bench provokes this with the counter enabled on every clock. It drives a write strobe and sets cmpC and cmpD to the current count, both in the same cycle. Output C is preset high and output D preset low, and the colliding write carries zeros. A correct block must then give C low and D high. That outcome rules out both "write wins" and "toggle the written value".

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int CTL_W     = 8;
  localparam int SYS_DIV_W = 3;  // system clock divide by up to 8
  localparam int SUB_DIV_W = 4;  // subclock divide by up to 16

  typedef enum logic [2:0] {
    SEL_SYS1  = 3'd0,
    SEL_SYS2  = 3'd1,
    SEL_SYS4  = 3'd2,
    SEL_SYS8  = 3'd3,
    SEL_SUB1  = 3'd4,
    SEL_SUB4  = 3'd5,
    SEL_SUB16 = 3'd6,
    SEL_EXT   = 3'd7
  } clkSel_e;

  typedef struct packed {
    logic cntEn;     // advance counter this cycle
    logic clrOnA;    // clear on compare A selected
    logic presetWr;  // level preset write this cycle
    logic presetC;   // written level for output C
    logic presetD;   // written level for output D
  } ctlStrobe_t;
endpackage

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             subTick,
  input  logic             extEvent,
  input  logic             regWe,
  input  logic [CTL_W-1:0] regWdata,
  output logic [CTL_W-1:0] regRdata,
  output ctlStrobe_t       strobe
);
  localparam int STORE_W = CTL_W - 2;

  logic [STORE_W-1:0]   ctlReg;
  logic [SYS_DIV_W-1:0] sysDiv;
  logic [SUB_DIV_W-1:0] subDiv;
  logic [SYNC_STAGES:0] syncChain;
  logic                 extRise;
  logic                 rawEn;
  clkSel_e              clkSel;
  logic                 unusedBits;

  assign unusedBits = ^regWdata[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ctlReg <= '0;
    else if (regWe) ctlReg <= regWdata[CTL_W-1:2];
  end

  assign regRdata = {ctlReg, 2'b00};
  assign clkSel   = clkSel_e'(ctlReg[4:2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysDiv <= '0;
    else       sysDiv <= sysDiv + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        subDiv <= '0;
    else if (subTick) subDiv <= subDiv + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], extEvent};
  end

  assign extRise = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  always_comb begin
    case (clkSel)
      SEL_SYS1:  rawEn = 1'b1;
      SEL_SYS2:  rawEn = sysDiv[0];
      SEL_SYS4:  rawEn = &sysDiv[1:0];
      SEL_SYS8:  rawEn = &sysDiv;
      SEL_SUB1:  rawEn = subTick;
      SEL_SUB4:  rawEn = subTick & (&subDiv[1:0]);
      SEL_SUB16: rawEn = subTick & (&subDiv);
      SEL_EXT:   rawEn = extRise;
      default:   rawEn = 1'b0;
    endcase
  end

  assign strobe.cntEn    = rawEn;
  assign strobe.clrOnA   = ctlReg[5];
  assign strobe.presetWr = regWe;
  assign strobe.presetC  = regWdata[2];
  assign strobe.presetD  = regWdata[3];
endmodule

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpC,
  input  logic [CNT_W-1:0] cmpD,
  output logic [CNT_W-1:0] count,
  output logic             matchA,
  output logic [1:0]       matchCd,
  output logic [1:0]       levelCd
);
  localparam int NUM_OUT = 2;

  logic [NUM_OUT-1:0][CNT_W-1:0] cmpOut;
  logic [NUM_OUT-1:0]            presetBits;

  assign cmpOut     = {cmpD, cmpC};
  assign presetBits = {strobe.presetD, strobe.presetC};
  assign matchA     = strobe.cntEn && (count == cmpA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      count <= '0;
    else if (strobe.cntEn)
      count <= (strobe.clrOnA && (count == cmpA)) ? '0 : count + 1'b1;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : gOut
    logic fired;
    logic level;

    assign matchCd[g] = strobe.cntEn && (count == cmpOut[g]);
    assign levelCd[g] = level;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fired <= 1'b0;
        level <= 1'b0;
      end else if (matchCd[g]) begin
        level <= ~level;
        fired <= 1'b1;
      end else if (strobe.presetWr && !fired) begin
        level <= presetBits[g];
      end
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             subTick,
  input  logic             extEvent,
  input  logic             regWe,
  input  logic [CTL_W-1:0] regWdata,
  output logic [CTL_W-1:0] regRdata,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpC,
  input  logic [CNT_W-1:0] cmpD,
  output logic [CNT_W-1:0] count,
  output logic             matchA,
  output logic             matchC,
  output logic             matchD,
  output logic             outC,
  output logic             outD
);
  ctlStrobe_t strobe;
  logic [1:0] matchCd;
  logic [1:0] levelCd;

  cmp_timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .subTick  (subTick),
    .extEvent (extEvent),
    .regWe    (regWe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .strobe   (strobe)
  );

  cmp_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmpA    (cmpA),
    .cmpC    (cmpC),
    .cmpD    (cmpD),
    .count   (count),
    .matchA  (matchA),
    .matchCd (matchCd),
    .levelCd (levelCd)
  );

  assign matchC = matchCd[0];
  assign matchD = matchCd[1];
  assign outC   = levelCd[0];
  assign outD   = levelCd[1];
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [7:0]       regWdata,
  input logic [7:0]       regRdata,
  input logic [CNT_W-1:0] count,
  input logic             matchA,
  input logic             matchC,
  input logic             matchD,
  input logic             outC,
  input logic             outD
);
  AST_READBACK_MASK: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWe) |-> regRdata == ($past(regWdata) & 8'hFC)); // R2

  AST_STEP_OR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(count) |-> (count == CNT_W'($past(count) + 1'b1)) || (count == '0)); // R6

  AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rstN)
    (matchA && regRdata[7]) |=> count == '0); // R7

  AST_TOGGLE_C: assert property (@(posedge clk) disable iff (!rstN)
    matchC |=> outC != $past(outC)); // R10

  AST_TOGGLE_D: assert property (@(posedge clk) disable iff (!rstN)
    matchD |=> outD != $past(outD)); // R10
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .count    (count),
  .matchA   (matchA),
  .matchC   (matchC),
  .matchD   (matchD),
  .outC     (outC),
  .outD     (outD)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        subTick = 1'b0;
  logic        extEvent = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regWdata = 8'h00;
  logic [7:0]  regRdata;
  logic [15:0] cmpA = 16'hFFFF;
  logic [15:0] cmpC = 16'hFFFF;
  logic [15:0] cmpD = 16'hFFFF;
  logic [15:0] count;
  logic        matchA, matchC, matchD, outC, outD;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk(clk), .rstN(rstN), .subTick(subTick), .extEvent(extEvent),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .cmpA(cmpA), .cmpC(cmpC), .cmpD(cmpD), .count(count),
    .matchA(matchA), .matchC(matchC), .matchD(matchD),
    .outC(outC), .outD(outD)
  );

  // subclock tick: high every other system clock, never interrupted
  initial forever begin
    @(negedge clk);
    subTick = ~subTick;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    regWe = 1'b0;
    extEvent = 1'b0;
    cmpA = 16'hFFFF; cmpC = 16'hFFFF; cmpD = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeCtl(input logic [7:0] v);
    regWe = 1'b1;
    regWdata = v;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic extStep();
    extEvent = 1'b1;
    @(negedge clk);
    extEvent = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [15:0] c0, prev, expCnt;

    // R1: state held in reset
    repeat (2) @(negedge clk);
    check(regRdata == 8'h00, "R1 rdata", regRdata, 0);
    check(count == 16'h0, "R1 count", count, 0);
    check(outC == 1'b0 && outD == 1'b0, "R1 outputs", {outD, outC}, 0);
    check(matchA == 1'b0, "R1 matchA", matchA, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: readback sweep over every write value
    for (int v = 0; v < 256; v++) begin
      writeCtl(8'(v));
      check(regRdata == (8'(v) & 8'hFC), "R2 readback", regRdata, v & 8'hFC);
    end

    // R3 / R4: rate per clock select, phase-independent window
    for (int cs = 0; cs < 7; cs++) begin
      int win, expD;
      doReset();
      writeCtl(8'(cs << 4));
      c0 = count;
      win  = (cs < 4) ? 64 : 128;
      expD = (cs < 4) ? (64 >> cs) : (64 >> (2 * (cs - 4)));
      repeat (win) @(negedge clk);
      check(16'(count - c0) == 16'(expD), (cs < 4) ? "R3 sys rate" : "R4 sub rate",
            16'(count - c0), expD);
    end

    // R5: external edges
    doReset();
    writeCtl(8'h70);
    c0 = count;
    repeat (5) @(negedge clk);
    check(count == c0, "R5 no edge no count", count, c0);
    extEvent = 1'b1;
    @(negedge clk);
    check(count == c0, "R5 latency 1", count, c0);
    @(negedge clk);
    check(count == c0, "R5 latency 2", count, c0);
    @(negedge clk);
    check(count == 16'(c0 + 1), "R5 latency 3", count, c0 + 1);
    repeat (4) @(negedge clk);
    check(count == 16'(c0 + 1), "R5 level counts once", count, c0 + 1);
    extEvent = 1'b0;
    repeat (3) @(negedge clk);
    for (int w = 1; w <= 4; w++) begin
      extEvent = 1'b1;
      repeat (w) @(negedge clk);
      extEvent = 1'b0;
      repeat (3) @(negedge clk);
    end
    check(count == 16'(c0 + 5), "R5 pulse train", count, c0 + 5);

    // R6: free-running wrap
    doReset();
    for (int i = 0; i < 70000 && count != 16'hFFFE; i++) @(negedge clk);
    @(negedge clk);
    check(count == 16'hFFFF, "R6 top", count, 16'hFFFF);
    @(negedge clk);
    check(count == 16'h0000, "R6 wrap", count, 0);

    // R7 / R8: clear-on-A period sweep
    for (int a = 3; a <= 10; a++) begin
      doReset();
      writeCtl(8'h70);
      cmpA = 16'(a);
      writeCtl(8'h80);
      prev = count;
      for (int k = 0; k < 3 * (a + 1); k++) begin
        check(matchA == (prev == 16'(a)), "R8 matchA", matchA, prev == 16'(a));
        @(negedge clk);
        expCnt = (prev == 16'(a)) ? 16'h0 : 16'(prev + 1);
        check(count == expCnt, "R7 clear sequence", count, expCnt);
        prev = count;
      end
    end

    // R9 / R10 / R11: presets and toggles, single-stepped by external edges
    doReset();
    writeCtl(8'h78);
    check(outD == 1'b1 && outC == 1'b0, "R9 preset D1 C0", {outD, outC}, 2);
    writeCtl(8'h74);
    check(outD == 1'b0 && outC == 1'b1, "R9 preset D0 C1", {outD, outC}, 1);
    c0 = count;
    cmpC = 16'(c0 + 2);
    cmpD = 16'(c0 + 3);
    extStep();
    writeCtl(8'h70);
    check(outC == 1'b0, "R9 reload before match", outC, 0);
    extStep();
    check(outC == 1'b0 && outD == 1'b0, "R9 held before match", {outD, outC}, 0);
    extStep();
    check(outC == 1'b1 && outD == 1'b0, "R10 first toggle C", {outD, outC}, 1);
    extStep();
    check(outD == 1'b1, "R10 first toggle D", outD, 1);
    writeCtl(8'h70);
    check(outC == 1'b1 && outD == 1'b1, "R11 write ignored after match", {outD, outC}, 3);
    cmpC = 16'(count + 1);
    extStep();
    check(outC == 1'b1, "R10 no match no toggle", outC, 1);
    extStep();
    check(outC == 1'b0, "R10 second toggle C", outC, 0);

    // R12: write and first match in the same cycle
    doReset();
    writeCtl(8'h04);
    check(outC == 1'b1 && outD == 1'b0, "R9 preset before collision", {outD, outC}, 1);
    cmpC = count;
    cmpD = count;
    regWe = 1'b1;
    regWdata = 8'h00;
    @(negedge clk);
    regWe = 1'b0;
    check(outC == 1'b0, "R12 C toggles old level", outC, 0);
    check(outD == 1'b1, "R12 D toggles old level", outD, 1);
    check(regRdata == 8'h00, "R2 collision readback", regRdata, 0);

    finishRun();
  end
endmodule